// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block collects interrupt requests from eight sources and presents one interrupt line to a processor. A request pulse on any input is held in a pending register until the processor services it. Each source can be masked on its own. The controller picks a winner among the unmasked pending requests and compares it with the requests already in service. It raises `intr` only when the winner outranks every source that is in service, so higher-priority handlers can nest inside lower-priority ones.

The processor answers with a one-cycle `inta` strobe. The controller then moves the winner from pending to in-service, and one cycle later it presents an 8-bit vector. The upper five bits of the vector are a programmable base and the lower three bits are the source number. An end-of-interrupt strobe retires the highest-priority source in service. There are two priority schemes. In the fixed scheme, source 0 ranks highest and source 7 lowest. In the rotating scheme, the source retired by the last end-of-interrupt becomes the lowest rank, and the others follow it in circular order.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `intr` and `vec_valid` are 0, no source is masked, the fixed scheme is selected, the vector base is 0 and `vec_out` is 0.
- R2: In the fixed scheme, the source with the smallest index among eligible pending sources wins. Source 0 ranks highest and source 7 lowest.
- R3: A source whose bit in the mask register is 1 never causes `intr`. Its pending bit is kept, and it competes again once the mask bit is written to 0. A `mask_we` strobe loads `mask_wdata` into the mask register.
- R4: `intr` is 1 exactly when some unmasked source is pending and that winner ranks strictly higher than every source currently in service.
- R5: An `inta` strobe while `intr` is 1 sets the winner's in-service bit and clears its pending bit. `vec_valid` is 1 for exactly the one following cycle.
- R6: The vector is `{base[4:0], source[2:0]}`, with base in bits 7:3 and the source number in bits 2:0. It shows on `vec_out` from the cycle after the acknowledge and holds until the next acknowledge. A `mode_we` strobe loads `mode_base` as the base.
- R7: An `eoi` strobe clears only the in-service bit that ranks highest under the current scheme. Lower-ranked in-service bits stay set.
- R8: `mode_we` with `mode_rotate`=1 selects the rotating scheme, and `mode_rotate`=0 selects the fixed scheme. In the rotating scheme, each end-of-interrupt makes the retired source the lowest rank, and the next source in circular order becomes the highest.
- R9: An `inta` strobe while `intr` is 0 is ignored. `vec_valid` stays 0 and no pending or in-service bit changes.
- R10: A request input held high for a single cycle stays pending until it is acknowledged. Once acknowledged, it does not raise `intr` again unless its input is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Request inputs, a high level sets the pending bit |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask, 1 blocks a source |
| mode_we | input | 1 | Scheme and base write strobe |
| mode_rotate | input | 1 | 1 selects the rotating scheme, 0 the fixed scheme |
| mode_base | input | 5 | Vector base written by `mode_we` |
| eoi | input | 1 | End-of-interrupt strobe |
| inta | input | 1 | Acknowledge strobe from the processor |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | High for the cycle after an accepted acknowledge |
| vec_out | output | 8 | Vector of the last acknowledged source |

## Verification
The assertions assume that `inta` and `eoi` are single-cycle strobes that never coincide. They also assume that configuration writes fall between transactions. Under these assumptions, an accepted acknowledge adds exactly one in-service bit, and an end-of-interrupt removes exactly one. The stimulus issues each strobe from a separate task that returns it to 0 before the next task runs, so the strobes never overlap. Request inputs are driven as one-cycle pulses, which keeps the model free of ambiguity between the held level and the pending bit.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic {
      PRIO_FIXED  = 1'b0,
      PRIO_ROTATE = 1'b1
   } prio_mode_e;
endpackage

// File: rtl/prio_irq_pick.sv
// Circular priority finder: the position after `low` ranks highest.
module prio_irq_pick #(
   parameter int N_SRC = 8,
   parameter int ID_W  = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] cand,
   input  logic [ID_W-1:0]  low,
   output logic             any,
   output logic [ID_W-1:0]  idx,
   output logic [ID_W-1:0]  rank
);
   logic [ID_W-1:0]  pos [N_SRC];
   logic [N_SRC-1:0] rot;

   for (genvar k = 0; k < N_SRC; k++) begin : g_rot
      assign pos[k] = low + ID_W'(k + 1);
      assign rot[k] = cand[pos[k]];
   end

   always_comb begin
      any  = 1'b0;
      idx  = '0;
      rank = '0;
      for (int k = N_SRC - 1; k >= 0; k--) begin
         if (rot[k]) begin
            any  = 1'b1;
            idx  = pos[k];
            rank = ID_W'(k);
         end
      end
   end
endmodule

// File: rtl/prio_irq_ptr.sv
// Holds the scheme and the lowest-rank position.
module prio_irq_ptr
   import prio_irq_pkg::*;
#(
   parameter int N_SRC      = 8,
   parameter int ID_W       = $clog2(N_SRC),
   parameter bit HAS_ROTATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_we,
   input  logic            mode_rotate,
   input  logic            eoi_fire,
   input  logic [ID_W-1:0] eoi_idx,
   output logic [ID_W-1:0] low_eff
);
   localparam logic [ID_W-1:0] FIXED_LOW = ID_W'(N_SRC - 1);

   if (HAS_ROTATE) begin : g_rot
      prio_mode_e      mode_q;
      logic [ID_W-1:0] low_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= PRIO_FIXED;
            low_q  <= FIXED_LOW;
         end else begin
            if (mode_we)
               mode_q <= mode_rotate ? PRIO_ROTATE : PRIO_FIXED;
            if (eoi_fire && mode_q == PRIO_ROTATE)
               low_q <= eoi_idx;
         end
      end

      assign low_eff = (mode_q == PRIO_ROTATE) ? low_q : FIXED_LOW;

      // the lowest-rank position moves only on a retiring end-of-interrupt
      assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !eoi_fire |=> $stable(low_q));
   end else begin : g_fixed
      logic unused_ptr;
      assign unused_ptr = &{1'b0, clk, rst_n, mode_we, mode_rotate, eoi_fire, eoi_idx};
      assign low_eff    = FIXED_LOW;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_SRC      = 8,
   parameter int VEC_W      = 8,
   parameter bit HAS_ROTATE = 1'b1,
   localparam int ID_W      = $clog2(N_SRC),
   localparam int BASE_W    = VEC_W - ID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_req,
   input  logic              mask_we,
   input  logic [N_SRC-1:0]  mask_wdata,
   input  logic              mode_we,
   input  logic              mode_rotate,
   input  logic [BASE_W-1:0] mode_base,
   input  logic              eoi,
   input  logic              inta,
   output logic              intr,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec_out
);
   if (N_SRC < 2 || N_SRC != (1 << ID_W)) begin : g_bad_n
      $error("N_SRC must be a power of two of at least 2");
   end
   if (BASE_W < 1) begin : g_bad_w
      $error("VEC_W must exceed the source number width");
   end

   logic [N_SRC-1:0]  pend_q, isr_q, mask_q;
   logic [BASE_W-1:0] base_q;
   logic [VEC_W-1:0]  vec_q;
   logic              vv_q;

   logic [ID_W-1:0]   low_eff;
   logic              win_any, top_any;
   logic [ID_W-1:0]   win_idx, win_rank, top_idx, top_rank;
   logic [N_SRC-1:0]  eligible, ack_bit, eoi_bit;
   logic              ack, eoi_fire;

   assign eligible = pend_q & ~mask_q;

   prio_irq_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_win (
      .cand(eligible), .low(low_eff),
      .any(win_any), .idx(win_idx), .rank(win_rank));

   prio_irq_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_top (
      .cand(isr_q), .low(low_eff),
      .any(top_any), .idx(top_idx), .rank(top_rank));

   assign intr     = win_any && (!top_any || win_rank < top_rank);
   assign ack      = inta && intr;
   assign eoi_fire = eoi && top_any;
   assign ack_bit  = ack      ? (N_SRC'(1) << win_idx) : '0;
   assign eoi_bit  = eoi_fire ? (N_SRC'(1) << top_idx) : '0;

   prio_irq_ptr #(.N_SRC(N_SRC), .ID_W(ID_W), .HAS_ROTATE(HAS_ROTATE)) u_ptr (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_rotate(mode_rotate),
      .eoi_fire(eoi_fire), .eoi_idx(top_idx), .low_eff(low_eff));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         isr_q  <= '0;
         mask_q <= '0;
         base_q <= '0;
         vec_q  <= '0;
         vv_q   <= 1'b0;
      end else begin
         pend_q <= (pend_q | irq_req) & ~ack_bit;
         isr_q  <= (isr_q & ~eoi_bit) | ack_bit;
         vv_q   <= ack;
         if (ack)     vec_q  <= {base_q, win_idx};
         if (mask_we) mask_q <= mask_wdata;
         if (mode_we) base_q <= mode_base;
      end
   end

   assign vec_valid = vv_q;
   assign vec_out   = vec_q;

   // masking every source silences the interrupt line
   assert_all_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we && (&mask_wdata) |=> !intr);

   // an accepted acknowledge adds a new in-service bit
   assert_ack_enters_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (isr_q & ~$past(isr_q)) != '0);

   // the presented vector names a source that is in service
   assert_vec_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> isr_q[vec_out[ID_W-1:0]]);

   // an end-of-interrupt retires exactly one source
   assert_eoi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi && top_any && !inta |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

   // an acknowledge with no request pending is dropped
   assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inta && !intr |=> !vec_valid);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0, mwd = '0;
   logic       mwe = 1'b0, dwe = 1'b0, drot = 1'b0, eoi = 1'b0, inta = 1'b0;
   logic [4:0] dbase = '0;
   logic       intr, vv;
   logic [7:0] vec;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(req), .mask_we(mwe), .mask_wdata(mwd),
      .mode_we(dwe), .mode_rotate(drot), .mode_base(dbase), .eoi(eoi),
      .inta(inta), .intr(intr), .vec_valid(vv), .vec_out(vec));

   always #(PERIOD / 2) clk = ~clk;

   // behavioural reference model
   bit [7:0] m_pend, m_isr, m_mask, m_vec;
   bit [4:0] m_base;
   bit       m_rot, m_vv;
   int       m_low;

   function automatic int order_low();
      return m_rot ? m_low : 7;
   endfunction

   // first set source walking from the highest rank, -1 when none
   function automatic int first_of(bit [7:0] s);
      for (int k = 0; k < 8; k++)
         if (s[(order_low() + 1 + k) % 8]) return (order_low() + 1 + k) % 8;
      return -1;
   endfunction

   function automatic int rank_of(int src);
      return (src - order_low() - 1 + 16) % 8;
   endfunction

   function automatic bit model_intr();
      int w, t;
      w = first_of(m_pend & ~m_mask);
      t = first_of(m_isr);
      if (w < 0) return 1'b0;
      if (t < 0) return 1'b1;
      return rank_of(w) < rank_of(t);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = '0; m_isr = '0; m_mask = '0; m_vec = '0;
         m_base = '0; m_rot = 1'b0; m_vv = 1'b0; m_low = 7;
      end else begin
         int w, t;
         bit a;
         bit [7:0] ab, eb;
         w  = first_of(m_pend & ~m_mask);
         t  = first_of(m_isr);
         a  = inta && model_intr();
         ab = a ? 8'(1 << w) : 8'h00;
         eb = (eoi && t >= 0) ? 8'(1 << t) : 8'h00;
         if (a) m_vec = {m_base, 3'(w)};
         m_vv = a;
         if (eoi && t >= 0 && m_rot) m_low = t;
         m_pend = (m_pend | req) & ~ab;
         m_isr  = (m_isr & ~eb) | ab;
         if (mwe) m_mask = mwd;
         if (dwe) begin m_rot = drot; m_base = dbase; end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(intr == model_intr(), "R4 intr vs model", intr, model_intr());
         chk(vv == m_vv, "R5 vec_valid vs model", vv, m_vv);
         chk(vec == m_vec, "R6 vec_out vs model", vec, m_vec);
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask
   task automatic pulse_req(input bit [7:0] r);
      req = r; tick(); req = '0;
   endtask
   task automatic ack();
      inta = 1'b1; tick(); inta = 1'b0;
   endtask
   task automatic end_irq();
      eoi = 1'b1; tick(); eoi = 1'b0;
   endtask
   task automatic set_mode(input bit rot, input bit [4:0] b);
      dwe = 1'b1; drot = rot; dbase = b; tick(); dwe = 1'b0;
   endtask
   task automatic set_mask(input bit [7:0] m);
      mwe = 1'b1; mwd = m; tick(); mwe = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      chk(intr == 1'b0, "R1 intr after reset", intr, 0);
      chk(vv == 1'b0, "R1 vec_valid after reset", vv, 0);
      chk(vec == 8'h00, "R1 vec_out after reset", vec, 0);

      // fixed scheme, base 0x15 -> upper bits 0xA8
      set_mode(1'b0, 5'h15);
      pulse_req(8'h24);
      chk(intr == 1'b1, "R2 intr on pending", intr, 1);
      ack();
      chk(vv == 1'b1, "R5 vec_valid after ack", vv, 1);
      chk(vec == 8'hAA, "R2 source 2 beats 5", vec, 8'hAA);
      chk(intr == 1'b0, "R4 lower rank blocked by service", intr, 0);
      pulse_req(8'h01);
      chk(intr == 1'b1, "R4 higher rank nests", intr, 1);
      ack();
      chk(vec == 8'hA8, "R6 vector of source 0", vec, 8'hA8);
      end_irq();
      chk(intr == 1'b0, "R7 eoi retired source 0 only", intr, 0);
      end_irq();
      chk(intr == 1'b1, "R7 second eoi frees source 5", intr, 1);
      ack();
      chk(vec == 8'hAD, "R6 vector of source 5", vec, 8'hAD);
      tick();
      chk(vv == 1'b0, "R5 vec_valid one cycle", vv, 0);
      chk(vec == 8'hAD, "R6 vector held", vec, 8'hAD);
      end_irq();
      chk(intr == 1'b0, "R10 served pulse does not refire", intr, 0);

      // masking
      set_mask(8'h08);
      pulse_req(8'h08);
      tick(3);
      chk(intr == 1'b0, "R3 masked source silent", intr, 0);
      set_mask(8'h00);
      chk(intr == 1'b1, "R10 pulse kept pending", intr, 1);
      ack();
      chk(vec == 8'hAB, "R3 unmasked source served", vec, 8'hAB);
      end_irq();

      // stray acknowledge
      set_mask(8'h40);
      pulse_req(8'h40);
      ack();
      chk(vv == 1'b0, "R9 stray inta ignored", vv, 0);
      chk(vec == 8'hAB, "R9 vector unchanged", vec, 8'hAB);
      set_mask(8'h00);
      chk(intr == 1'b1, "R9 pending survived stray inta", intr, 1);
      ack();
      chk(vec == 8'hAE, "R9 source 6 served later", vec, 8'hAE);
      end_irq();

      // rotating scheme, base 0x02 -> upper bits 0x10
      set_mode(1'b1, 5'h02);
      pulse_req(8'h04);
      ack();
      chk(vec == 8'h12, "R8 first rotate service", vec, 8'h12);
      end_irq();
      pulse_req(8'h12);
      ack();
      chk(vec == 8'h14, "R8 source 4 outranks 1 after rotation", vec, 8'h14);
      end_irq();
      chk(intr == 1'b1, "R8 source 1 still pending", intr, 1);
      ack();
      chk(vec == 8'h11, "R8 source 1 served", vec, 8'h11);
      end_irq();
      pulse_req(8'h03);
      ack();
      chk(vec == 8'h10, "R8 source 0 outranks 1 after rotation", vec, 8'h10);
      end_irq();
      ack();
      chk(vec == 8'h11, "R8 source 1 served last", vec, 8'h11);
      end_irq();

      // back to fixed scheme
      set_mode(1'b0, 5'h1F);
      pulse_req(8'h81);
      ack();
      chk(vec == 8'hF8, "R2 fixed scheme restored", vec, 8'hF8);
      end_irq();
      ack();
      chk(vec == 8'hFF, "R2 source 7 last", vec, 8'hFF);
      end_irq();
      tick(2);
      chk(intr == 1'b0, "R10 all served", intr, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule